// File: doc/BRIEF.md
# Segmented Effective Address Generator

This unit forms the memory address of a decoded data operand for a processor that uses segment:offset addressing. From a mode code and a few register-select fields it adds up to three terms: a base register (BX or BP), an index register (SI or DI) and a displacement. The displacement is either a full 16-bit value or an 8-bit value that is sign-extended. The sum wraps to 16 bits and is the operand offset.

The unit then picks one of four segment registers. Operands reached through BP default to the stack segment and all other operands default to the data segment. An override input can name any segment instead, but a string-destination access always uses the extra segment with DI as the offset. The physical address is the segment value shifted left by four bits plus the offset, truncated to 20 bits.

All results are registered once, so a request presented with `valid_i` appears on the outputs one clock later. Instruction fetch addressing is not handled here.

Top module: `seg_ea_gen`

## Requirements
- R1: Outputs are registered. `valid_o` equals `valid_i` from the previous clock. While `rst_ni` is low, `valid_o`, `ofs_o`, `seg_id_o`, `seg_o` and `pa_o` are all zero.
- R2: `pa_o` = ((`seg_o` << 4) + `ofs_o`) mod 2^20. A carry out of bit 19 is dropped.
- R3: Mode 0 is the direct mode. The offset is `disp_i` taken as a full 16-bit value, whatever `disp_wide_i` is, and the default segment is DS.
- R4: Mode 1 gives an offset equal to the register chosen by `reg_sel_i` (0 BX, 1 BP, 2 SI, 3 DI). Mode 2 gives that register plus the displacement.
- R5: Mode 3 gives base plus index. Mode 4 gives base plus index plus displacement. `base_sel_i` picks 0 BX or 1 BP, and `idx_sel_i` picks 0 SI or 1 DI.
- R6: In modes 2 and 4, `disp_wide_i`=1 uses all 16 bits of `disp_i`. `disp_wide_i`=0 uses `disp_i[7:0]` sign-extended to 16 bits and ignores `disp_i[15:8]`.
- R7: The offset sum wraps modulo 65536.
- R8: Segment codes on `seg_id_o` are 0 ES, 1 CS, 2 SS, 3 DS. With no override and no string destination, the segment is SS when BP is one of the terms and DS otherwise. `seg_o` carries the value of the chosen register.
- R9: With `ovr_en_i`=1 and `str_dst_i`=0, the segment is the one coded on `ovr_seg_i`, and the offset is unchanged.
- R10: With `str_dst_i`=1, the offset is DI and the segment is ES. The mode, select, displacement and override inputs have no effect.
- R11: Mode codes 5, 6 and 7 behave exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| mode_i | input | 3 | Addressing mode code |
| reg_sel_i | input | 2 | Single register select for modes 1 and 2 |
| base_sel_i | input | 1 | Base select: 0 BX, 1 BP |
| idx_sel_i | input | 1 | Index select: 0 SI, 1 DI |
| disp_wide_i | input | 1 | 1: 16-bit displacement, 0: sign-extended 8-bit |
| disp_i | input | 16 | Displacement or direct offset |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| es_i | input | 16 | ES value |
| cs_i | input | 16 | CS value |
| ss_i | input | 16 | SS value |
| ds_i | input | 16 | DS value |
| str_dst_i | input | 1 | String destination access |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment code |
| valid_o | output | 1 | Result valid |
| ofs_o | output | 16 | Offset |
| seg_id_o | output | 2 | Chosen segment code |
| seg_o | output | 16 | Chosen segment value |
| pa_o | output | 20 | Physical address |

## Verification
The bench uses the default parameters: a 16-bit offset, a 4-bit segment shift and the registered output stage. With 16-bit operands, both wrap points can be hit with small directed values. A base of FFF0h plus an index of 0020h carries out of the offset. A segment of FFFFh with a small offset carries out of the 20-bit physical sum. Every mode code, including the unused ones, and each segment source is driven through a queue of expected results. The vectors come back to back with idle gaps between them, so the one-cycle valid timing is also checked.

// File: rtl/sea_pkg.sv
package sea_pkg;
  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_REG     = 3'd1,
    MODE_REG_DSP = 3'd2,
    MODE_BI      = 3'd3,
    MODE_BI_DSP  = 3'd4
  } sea_mode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } sea_seg_e;

  typedef enum logic [1:0] {
    RSEL_BX = 2'd0,
    RSEL_BP = 2'd1,
    RSEL_SI = 2'd2,
    RSEL_DI = 2'd3
  } sea_rsel_e;

  localparam int unsigned DISP_SHORT_W = 8;
endpackage

// File: rtl/sea_addend_sel.sv
module sea_addend_sel
  import sea_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic [2:0]       mode_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             base_sel_i,
  input  logic             idx_sel_i,
  input  logic             disp_wide_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic             str_dst_i,
  output logic [OFS_W-1:0] term_a_o,
  output logic [OFS_W-1:0] term_b_o,
  output logic [OFS_W-1:0] term_c_o,
  output logic             bp_used_o
);
  localparam int unsigned EXT_W = OFS_W - DISP_SHORT_W;

  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] single_reg;
  logic [OFS_W-1:0] base_reg;
  logic [OFS_W-1:0] idx_reg;

  assign disp_ext = disp_wide_i ? disp_i
                  : {{EXT_W{disp_i[DISP_SHORT_W-1]}}, disp_i[DISP_SHORT_W-1:0]};
  assign base_reg = base_sel_i ? bp_i : bx_i;
  assign idx_reg  = idx_sel_i  ? di_i : si_i;

  always_comb begin
    unique case (sea_rsel_e'(reg_sel_i))
      RSEL_BX: single_reg = bx_i;
      RSEL_BP: single_reg = bp_i;
      RSEL_SI: single_reg = si_i;
      default: single_reg = di_i;
    endcase
  end

  always_comb begin
    term_a_o  = '0;
    term_b_o  = '0;
    term_c_o  = '0;
    bp_used_o = 1'b0;
    if (str_dst_i) begin
      term_a_o = di_i;
    end else begin
      case (mode_i)
        MODE_REG: begin
          term_a_o  = single_reg;
          bp_used_o = (reg_sel_i == RSEL_BP);
        end
        MODE_REG_DSP: begin
          term_a_o  = single_reg;
          term_c_o  = disp_ext;
          bp_used_o = (reg_sel_i == RSEL_BP);
        end
        MODE_BI: begin
          term_a_o  = base_reg;
          term_b_o  = idx_reg;
          bp_used_o = base_sel_i;
        end
        MODE_BI_DSP: begin
          term_a_o  = base_reg;
          term_b_o  = idx_reg;
          term_c_o  = disp_ext;
          bp_used_o = base_sel_i;
        end
        // direct and unused codes: full-width offset from the instruction
        default: term_c_o = disp_i;
      endcase
    end
  end
endmodule

// File: rtl/sea_offset_sum.sv
module sea_offset_sum #(
  parameter int unsigned OFS_W = 16
) (
  input  logic [OFS_W-1:0] term_a_i,
  input  logic [OFS_W-1:0] term_b_i,
  input  logic [OFS_W-1:0] term_c_i,
  output logic [OFS_W-1:0] ofs_o
);
  // carries beyond OFS_W are dropped
  assign ofs_o = term_a_i + term_b_i + term_c_i;
endmodule

// File: rtl/sea_seg_pick.sv
module sea_seg_pick
  import sea_pkg::*;
#(
  parameter int unsigned OFS_W = 16
) (
  input  logic             str_dst_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_seg_i,
  input  logic             bp_used_i,
  input  logic [OFS_W-1:0] es_i,
  input  logic [OFS_W-1:0] cs_i,
  input  logic [OFS_W-1:0] ss_i,
  input  logic [OFS_W-1:0] ds_i,
  output logic [1:0]       seg_id_o,
  output logic [OFS_W-1:0] seg_o
);
  always_comb begin
    if (str_dst_i)      seg_id_o = SEG_ES;
    else if (ovr_en_i)  seg_id_o = ovr_seg_i;
    else if (bp_used_i) seg_id_o = SEG_SS;
    else                seg_id_o = SEG_DS;
  end

  always_comb begin
    unique case (sea_seg_e'(seg_id_o))
      SEG_ES:  seg_o = es_i;
      SEG_CS:  seg_o = cs_i;
      SEG_SS:  seg_o = ss_i;
      default: seg_o = ds_i;
    endcase
  end
endmodule

// File: rtl/sea_phys_sum.sv
module sea_phys_sum #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic [OFS_W-1:0]           seg_i,
  input  logic [OFS_W-1:0]           ofs_i,
  output logic [OFS_W+SEG_SHIFT-1:0] pa_o
);
  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic [PA_W-1:0] seg_sh;
  logic [PA_W-1:0] ofs_z;

  assign seg_sh = {seg_i, {SEG_SHIFT{1'b0}}};
  assign ofs_z  = {{SEG_SHIFT{1'b0}}, ofs_i};
  assign pa_o   = seg_sh + ofs_z;
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter bit          PIPE      = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [2:0]                 mode_i,
  input  logic [1:0]                 reg_sel_i,
  input  logic                       base_sel_i,
  input  logic                       idx_sel_i,
  input  logic                       disp_wide_i,
  input  logic [OFS_W-1:0]           disp_i,
  input  logic [OFS_W-1:0]           bx_i,
  input  logic [OFS_W-1:0]           bp_i,
  input  logic [OFS_W-1:0]           si_i,
  input  logic [OFS_W-1:0]           di_i,
  input  logic [OFS_W-1:0]           es_i,
  input  logic [OFS_W-1:0]           cs_i,
  input  logic [OFS_W-1:0]           ss_i,
  input  logic [OFS_W-1:0]           ds_i,
  input  logic                       str_dst_i,
  input  logic                       ovr_en_i,
  input  logic [1:0]                 ovr_seg_i,
  output logic                       valid_o,
  output logic [OFS_W-1:0]           ofs_o,
  output logic [1:0]                 seg_id_o,
  output logic [OFS_W-1:0]           seg_o,
  output logic [OFS_W+SEG_SHIFT-1:0] pa_o
);
  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic [OFS_W-1:0] term_a, term_b, term_c;
  logic             bp_used;
  logic [OFS_W-1:0] ofs_d;
  logic [1:0]       seg_id_d;
  logic [OFS_W-1:0] seg_d;
  logic [PA_W-1:0]  pa_d;

  sea_addend_sel #(.OFS_W(OFS_W)) u_addend (
    .mode_i      (mode_i),
    .reg_sel_i   (reg_sel_i),
    .base_sel_i  (base_sel_i),
    .idx_sel_i   (idx_sel_i),
    .disp_wide_i (disp_wide_i),
    .disp_i      (disp_i),
    .bx_i        (bx_i),
    .bp_i        (bp_i),
    .si_i        (si_i),
    .di_i        (di_i),
    .str_dst_i   (str_dst_i),
    .term_a_o    (term_a),
    .term_b_o    (term_b),
    .term_c_o    (term_c),
    .bp_used_o   (bp_used)
  );

  sea_offset_sum #(.OFS_W(OFS_W)) u_ofs (
    .term_a_i (term_a),
    .term_b_i (term_b),
    .term_c_i (term_c),
    .ofs_o    (ofs_d)
  );

  sea_seg_pick #(.OFS_W(OFS_W)) u_seg (
    .str_dst_i (str_dst_i),
    .ovr_en_i  (ovr_en_i),
    .ovr_seg_i (ovr_seg_i),
    .bp_used_i (bp_used),
    .es_i      (es_i),
    .cs_i      (cs_i),
    .ss_i      (ss_i),
    .ds_i      (ds_i),
    .seg_id_o  (seg_id_d),
    .seg_o     (seg_d)
  );

  sea_phys_sum #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_pa (
    .seg_i (seg_d),
    .ofs_i (ofs_d),
    .pa_o  (pa_d)
  );

  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          valid_o  <= 1'b0;
          ofs_o    <= '0;
          seg_id_o <= '0;
          seg_o    <= '0;
          pa_o     <= '0;
        end else begin
          valid_o <= valid_i;
          if (valid_i) begin
            ofs_o    <= ofs_d;
            seg_id_o <= seg_id_d;
            seg_o    <= seg_d;
            pa_o     <= pa_d;
          end
        end
      end
    end else begin : g_comb
      assign valid_o  = valid_i;
      assign ofs_o    = ofs_d;
      assign seg_id_o = seg_id_d;
      assign seg_o    = seg_d;
      assign pa_o     = pa_d;
    end
  endgenerate
endmodule

module sea_checker #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       valid_i,
  input logic [2:0]                 mode_i,
  input logic [1:0]                 reg_sel_i,
  input logic                       base_sel_i,
  input logic [OFS_W-1:0]           disp_i,
  input logic [OFS_W-1:0]           di_i,
  input logic [OFS_W-1:0]           es_i,
  input logic                       str_dst_i,
  input logic                       ovr_en_i,
  input logic [1:0]                 ovr_seg_i,
  input logic                       valid_o,
  input logic [OFS_W-1:0]           ofs_o,
  input logic [1:0]                 seg_id_o,
  input logic [OFS_W-1:0]           seg_o,
  input logic [OFS_W+SEG_SHIFT-1:0] pa_o
);
  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic bp_req;
  assign bp_req = ((mode_i == 3'd1 || mode_i == 3'd2) && reg_sel_i == 2'd1) ||
                  ((mode_i == 3'd3 || mode_i == 3'd4) && base_sel_i);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid lost"); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("spurious valid"); // R1
  AST_PA_COMPOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pa_o == PA_W'({seg_o, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, ofs_o}))
    else $error("pa mismatch"); // R2
  AST_DIRECT_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !str_dst_i && (mode_i == 3'd0 || mode_i > 3'd4)) |=> ofs_o == $past(disp_i))
    else $error("direct offset"); // R3
  AST_BP_STACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !str_dst_i && !ovr_en_i && bp_req) |=> seg_id_o == 2'd2)
    else $error("bp default seg"); // R8
  AST_OVR_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !str_dst_i && ovr_en_i) |=> seg_id_o == $past(ovr_seg_i))
    else $error("override seg"); // R9
  AST_STR_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && str_dst_i) |=> (seg_id_o == 2'd0 && ofs_o == $past(di_i) && seg_o == $past(es_i)))
    else $error("string dest"); // R10
endmodule

bind seg_ea_gen sea_checker #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (.*);

// File: tb/seg_ea_gen_tb.sv
`timescale 1ns/1ps
module seg_ea_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  reg_sel_i = '0;
  logic        base_sel_i = 1'b0, idx_sel_i = 1'b0, disp_wide_i = 1'b0;
  logic [15:0] disp_i = '0;
  logic [15:0] bx = 16'h2000, bp = 16'h0300, si = 16'h3000, di = 16'h0044;
  logic [15:0] es = 16'h4000, cs = 16'h0AFD, ss = 16'h7000, ds = 16'h1000;
  logic        str_dst_i = 1'b0, ovr_en_i = 1'b0;
  logic [1:0]  ovr_seg_i = '0;
  logic        valid_o;
  logic [15:0] ofs_o, seg_o;
  logic [1:0]  seg_id_o;
  logic [19:0] pa_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    string       tag;
    logic [15:0] ofs;
    logic [1:0]  sid;
    logic [15:0] seg;
    logic [19:0] pa;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  seg_ea_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .reg_sel_i(reg_sel_i), .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i),
    .disp_wide_i(disp_wide_i), .disp_i(disp_i),
    .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di),
    .es_i(es), .cs_i(cs), .ss_i(ss), .ds_i(ds),
    .str_dst_i(str_dst_i), .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
    .valid_o(valid_o), .ofs_o(ofs_o), .seg_id_o(seg_id_o), .seg_o(seg_o), .pa_o(pa_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected-result model built from the requirement text
  function automatic exp_t model(input string tag, input logic [2:0] m, input logic [1:0] rs,
                                 input logic bs, input logic is, input logic w,
                                 input logic [15:0] d, input logic sd,
                                 input logic oe, input logic [1:0] os);
    exp_t e;
    logic [15:0] dx, r1;
    logic [16:0] acc;
    logic [19:0] full;
    bit   via_bp;
    dx = w ? d : {{8{d[7]}}, d[7:0]};
    r1 = (rs == 2'd0) ? bx : (rs == 2'd1) ? bp : (rs == 2'd2) ? si : di;
    via_bp = 0;
    if (sd) acc = {1'b0, di};
    else if (m == 3'd1) begin acc = {1'b0, r1}; via_bp = (rs == 2'd1); end
    else if (m == 3'd2) begin acc = r1 + dx; via_bp = (rs == 2'd1); end
    else if (m == 3'd3 || m == 3'd4) begin
      acc = (bs ? bp : bx) + (is ? di : si);
      if (m == 3'd4) acc = acc[15:0] + dx;
      via_bp = bs;
    end else acc = {1'b0, d};
    e.tag = tag;
    e.ofs = acc[15:0];
    e.sid = sd ? 2'd0 : oe ? os : via_bp ? 2'd2 : 2'd3;
    e.seg = (e.sid == 2'd0) ? es : (e.sid == 2'd1) ? cs : (e.sid == 2'd2) ? ss : ds;
    full  = e.seg * 20'd16;
    e.pa  = full + 20'(e.ofs);
    return e;
  endfunction

  task automatic apply(input string tag, input logic [2:0] m, input logic [1:0] rs,
                       input logic bs, input logic is, input logic w, input logic [15:0] d,
                       input logic sd = 0, input logic oe = 0, input logic [1:0] os = 0);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; reg_sel_i = rs; base_sel_i = bs; idx_sel_i = is;
    disp_wide_i = w; disp_i = d; str_dst_i = sd; ovr_en_i = oe; ovr_seg_i = os;
    sb_q.push_back(model(tag, m, rs, bs, is, w, d, sd, oe, os));
  endtask

  task automatic idle_chk();
    @(negedge clk);
    valid_i = 1'b0;
    @(posedge clk); #1;
    check("R1 idle valid_o", 32'(valid_o), 32'd0);
  endtask

  // monitor: pops expected items as results appear
  always @(posedge clk) begin
    #1;
    if (rst_n && valid_o) begin
      if (sb_q.size() == 0) check("R1 unexpected valid_o", 32'(valid_o), 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " ofs"}, 32'(ofs_o), 32'(e.ofs));
        check({e.tag, " seg_id"}, 32'(seg_id_o), 32'(e.sid));
        check({e.tag, " seg"}, 32'(seg_o), 32'(e.seg));
        check({e.tag, " pa"}, 32'(pa_o), 32'(e.pa));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    valid_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid_o", 32'(valid_o), 32'd0);
    check("R1 reset pa_o", 32'(pa_o), 32'd0);
    check("R1 reset ofs_o", 32'(ofs_o), 32'd0);
    @(negedge clk); valid_i = 1'b0; rst_n = 1'b1;

    apply("R3 direct", 3'd0, 2'd0, 0, 0, 1, 16'h5000);
    apply("R3 direct narrow flag", 3'd0, 2'd0, 0, 0, 0, 16'h0080);
    apply("R4 reg BX", 3'd1, 2'd0, 0, 0, 0, 16'h0000);
    apply("R4 reg SI", 3'd1, 2'd2, 0, 0, 0, 16'h1111);
    apply("R4 reg DI", 3'd1, 2'd3, 0, 0, 0, 16'h0000);
    apply("R8 reg BP stack", 3'd1, 2'd1, 0, 0, 0, 16'h0000);
    idle_chk();
    apply("R4 rel BX+50", 3'd2, 2'd0, 0, 0, 0, 16'h0050);
    apply("R6 sign-ext F0", 3'd2, 2'd2, 0, 0, 0, 16'h00F0);
    apply("R6 upper ignored", 3'd2, 2'd2, 0, 0, 0, 16'h12F0);
    apply("R6 wide disp", 3'd2, 2'd3, 0, 0, 1, 16'h3000);
    apply("R5 BX+SI", 3'd3, 2'd0, 0, 0, 0, 16'h0000);
    apply("R8 BP+DI stack", 3'd3, 2'd0, 1, 1, 0, 16'h0000);
    apply("R5 BX+SI+2000", 3'd4, 2'd0, 0, 0, 1, 16'h2000);
    apply("R5 BP+SI-2", 3'd4, 2'd0, 1, 0, 0, 16'h00FE);
    idle_chk();
    @(negedge clk); bx = 16'hFFF0; si = 16'h0020;
    apply("R7 offset wrap", 3'd3, 2'd0, 0, 0, 0, 16'h0000);
    apply("R7 wrap with disp", 3'd4, 2'd0, 0, 0, 1, 16'hFFFF);
    idle_chk();
    @(negedge clk); ds = 16'hFFFF;
    apply("R2 pa wrap", 3'd0, 2'd0, 0, 0, 1, 16'h0020);
    apply("R2 pa top", 3'd0, 2'd0, 0, 0, 1, 16'h000F);
    apply("R9 override ES on BP", 3'd1, 2'd1, 0, 0, 0, 16'h0000, 0, 1, 2'd0);
    apply("R9 override CS", 3'd0, 2'd0, 0, 0, 1, 16'h0100, 0, 1, 2'd1);
    apply("R9 override SS", 3'd3, 2'd0, 0, 0, 0, 16'h0000, 0, 1, 2'd2);
    apply("R10 string dst", 3'd4, 2'd1, 1, 0, 1, 16'h7777, 1, 1, 2'd1);
    apply("R10 string dst mode3", 3'd3, 2'd0, 1, 1, 0, 16'h0000, 1, 0, 2'd0);
    apply("R11 mode5", 3'd5, 2'd1, 1, 1, 0, 16'h00C3);
    apply("R11 mode6", 3'd6, 2'd3, 1, 0, 0, 16'hABCD);
    apply("R11 mode7", 3'd7, 2'd2, 0, 1, 0, 16'h8001);
    idle_chk();
    repeat (2) @(posedge clk);
    #1;
    check("R1 scoreboard drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule